// File: doc/BRIEF.md
# Flag-Generating Integer ALU

This block is the purely combinational arithmetic and logic stage of a simple single-cycle processor. It takes two operands of equal, parameterised width and a 3-bit operation select. It returns a result of the same width and four status flags that describe that result: zero, negative, signed overflow and carry.

The block supports four operations: bitwise AND, bitwise OR, addition and subtraction. Each one has a fixed select code. Addition and subtraction share one adder. Subtraction is formed as `a + ~b + 1`, so the carry flag is the raw adder carry, and a 1 there means no borrow occurred. The other four select codes are unused. They give a zero result with both arithmetic flags cleared.

Top module: `flag_alu`

## Requirements
- R1: Select `3'b000` drives `f_o` with the bitwise AND of `a_i` and `b_i`.
- R2: Select `3'b001` drives `f_o` with the bitwise OR of `a_i` and `b_i`.
- R3: Select `3'b010` drives `f_o` with `(a_i + b_i) mod 2^WIDTH`, and `carry_o` is 1 exactly when the unsigned sum is `2^WIDTH` or more.
- R4: Select `3'b110` drives `f_o` with `(a_i - b_i) mod 2^WIDTH`, and `carry_o` is 1 exactly when `a_i >= b_i` as unsigned values (no borrow).
- R5: Under select `3'b010`, `ovf_o` is 1 exactly when the signed two's-complement sum of the operands lies outside the range representable in WIDTH bits.
- R6: Under select `3'b110`, `ovf_o` is 1 exactly when the signed two's-complement difference `a_i - b_i` lies outside the range representable in WIDTH bits.
- R7: `zero_o` is 1 exactly when every bit of `f_o` is 0, for every select code.
- R8: `neg_o` equals bit WIDTH-1 of `f_o`, for every select code.
- R9: Under selects `3'b000` and `3'b001`, `ovf_o` and `carry_o` are both 0.
- R10: Under the unused selects `3'b011`, `3'b100`, `3'b101` and `3'b111`, `f_o` is all zeros, `ovf_o` and `carry_o` are 0, and so `zero_o` is 1 and `neg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (subtrahend for subtraction) |
| sel_i | input | 3 | Operation select code |
| f_o | output | WIDTH | Result |
| zero_o | output | 1 | Result is all zeros |
| neg_o | output | 1 | Most significant bit of the result |
| ovf_o | output | 1 | Signed overflow of add or subtract |
| carry_o | output | 1 | Adder carry out (1 = no borrow on subtract) |

## Verification
The assertions are evaluated combinationally. They take for granted that the operands and the select are known, two-valued signals whenever they are sampled, and they place no constraint on which select codes appear. The bench uses a 4-bit configuration. It applies every pair of operand values under all eight select codes, so the stimulus is always fully defined. The sweep reaches every signed overflow boundary and every borrow case, and it also covers the four unused codes.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110
  } alu_op_e;

  function automatic logic op_is_arith(input logic [2:0] s);
    return (s == OP_ADD) || (s == OP_SUB);
  endfunction

  function automatic logic op_is_bitwise(input logic [2:0] s);
    return (s == OP_AND) || (s == OP_OR);
  endfunction

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             subtract,
  output logic [WIDTH-1:0] sum,
  output logic             carry,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] add_with_cin(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             cin
  );
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    b_eff = subtract ? ~b : b;
    wide  = add_with_cin(a, b_eff, subtract);
    sum   = wide[WIDTH-1:0];
    carry = wide[WIDTH];
    ovf   = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
  end
endmodule

// File: rtl/flag_alu_bitwise.sv
module flag_alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             pick_or,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y[i] = pick_or ? (a[i] | b[i]) : (a[i] & b[i]);
  end
endmodule

// File: rtl/flag_alu_status.sv
module flag_alu_status #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] f,
  output logic             zero,
  output logic             neg
);
  assign zero = ~|f;
  assign neg  = f[WIDTH-1];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       sel_i,
  output logic [WIDTH-1:0] f_o,
  output logic             zero_o,
  output logic             neg_o,
  output logic             ovf_o,
  output logic             carry_o
);
  // Internal events, named so the checker can observe them.
  logic             arith_en;
  logic             bitwise_en;
  logic [WIDTH-1:0] arith_sum;
  logic             arith_carry;
  logic             arith_ovf;
  logic [WIDTH-1:0] bitwise_y;

  assign arith_en   = op_is_arith(sel_i);
  assign bitwise_en = op_is_bitwise(sel_i);

  flag_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a        (a_i),
    .b        (b_i),
    .subtract (sel_i == OP_SUB),
    .sum      (arith_sum),
    .carry    (arith_carry),
    .ovf      (arith_ovf)
  );

  flag_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a       (a_i),
    .b       (b_i),
    .pick_or (sel_i == OP_OR),
    .y       (bitwise_y)
  );

  always_comb begin
    f_o     = '0;
    ovf_o   = 1'b0;
    carry_o = 1'b0;
    if (arith_en) begin
      f_o     = arith_sum;
      ovf_o   = arith_ovf;
      carry_o = arith_carry;
    end else if (bitwise_en) begin
      f_o = bitwise_y;
    end
  end

  flag_alu_status #(.WIDTH(WIDTH)) u_status (
    .f    (f_o),
    .zero (zero_o),
    .neg  (neg_o)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [2:0]       sel_i,
  input logic [WIDTH-1:0] f_o,
  input logic             zero_o,
  input logic             neg_o,
  input logic             ovf_o,
  input logic             carry_o,
  input logic [WIDTH-1:0] arith_sum,
  input logic             arith_carry
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R1
    a_r1_and_result: assert (sel_i != OP_AND || f_o == (a_i & b_i))
      else $error("a_r1_and_result");
    // R2
    a_r2_or_result: assert (sel_i != OP_OR || f_o == (a_i | b_i))
      else $error("a_r2_or_result");
    // R3 / R4: arithmetic outputs come straight from the shared adder
    a_r3_r4_adder_route: assert (!op_is_arith(sel_i) ||
                                 (f_o == arith_sum && carry_o == arith_carry))
      else $error("a_r3_r4_adder_route");
    // R5
    a_r5_add_overflow: assert (sel_i != OP_ADD ||
        ovf_o == ((a_i[MSB] == b_i[MSB]) && (f_o[MSB] != a_i[MSB])))
      else $error("a_r5_add_overflow");
    // R6
    a_r6_sub_overflow: assert (sel_i != OP_SUB ||
        ovf_o == ((a_i[MSB] != b_i[MSB]) && (f_o[MSB] != a_i[MSB])))
      else $error("a_r6_sub_overflow");
    // R7
    a_r7_zero_flag: assert (zero_o == (f_o == '0))
      else $error("a_r7_zero_flag");
    // R8
    a_r8_neg_flag: assert (neg_o == f_o[MSB])
      else $error("a_r8_neg_flag");
    // R9
    a_r9_bitwise_flags: assert (!op_is_bitwise(sel_i) || (!ovf_o && !carry_o))
      else $error("a_r9_bitwise_flags");
    // R10
    a_r10_unused_code: assert (op_is_arith(sel_i) || op_is_bitwise(sel_i) ||
        (f_o == '0 && !ovf_o && !carry_o && zero_o && !neg_o))
      else $error("a_r10_unused_code");
  end
endmodule

bind flag_alu flag_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .sel_i       (sel_i),
  .f_o         (f_o),
  .zero_o      (zero_o),
  .neg_o       (neg_o),
  .ovf_o       (ovf_o),
  .carry_o     (carry_o),
  .arith_sum   (arith_sum),
  .arith_carry (arith_carry)
);

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk; // 125 MHz

  logic [W-1:0] a, b, f;
  logic [2:0]   sel;
  logic         z, n, v, c;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  flag_alu #(.WIDTH(W)) dut (
    .a_i(a), .b_i(b), .sel_i(sel), .f_o(f),
    .zero_o(z), .neg_o(n), .ovf_o(v), .carry_o(c)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s a=%0d b=%0d sel=%0d actual=%0d expected=%0d",
               tag, what, a, b, sel, act, exp);
    end
  endtask

  function automatic int to_signed(input int u);
    return (u >= HALF) ? u - SPAN : u;
  endfunction

  task automatic run_vector(input int ua, input int ub, input int s);
    int ef, ev, ec;
    int sr;
    string ftag, ftagv, ftagc;
    @(posedge clk);
    a = W'(ua); b = W'(ub); sel = 3'(s);
    ef = 0; ev = 0; ec = 0;
    ftag = "R10"; ftagv = "R10"; ftagc = "R10";
    case (s)
      0: begin ef = ua & ub; ftag = "R1"; ftagv = "R9"; ftagc = "R9"; end
      1: begin ef = ua | ub; ftag = "R2"; ftagv = "R9"; ftagc = "R9"; end
      2: begin
        ef = (ua + ub) % SPAN;
        ec = (ua + ub >= SPAN) ? 1 : 0;
        sr = to_signed(ua) + to_signed(ub);
        ev = (sr < -HALF || sr > HALF - 1) ? 1 : 0;
        ftag = "R3"; ftagv = "R5"; ftagc = "R3";
      end
      6: begin
        ef = (ua - ub + SPAN) % SPAN;
        ec = (ua >= ub) ? 1 : 0;
        sr = to_signed(ua) - to_signed(ub);
        ev = (sr < -HALF || sr > HALF - 1) ? 1 : 0;
        ftag = "R4"; ftagv = "R6"; ftagc = "R4";
      end
      default: ;
    endcase
    @(negedge clk);
    check(ftag,  "result",   int'(f), ef);
    check(ftagv, "overflow", int'(v), ev);
    check(ftagc, "carry",    int'(c), ec);
    check("R7",  "zero",     int'(z), (ef == 0) ? 1 : 0);
    check("R8",  "negative", int'(n), (ef >= HALF) ? 1 : 0);
  endtask

  initial begin
    a = '0; b = '0; sel = 3'b000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state after reset: AND of zeros, R7 zero flag set, R9 flags clear
    check("R7", "idle zero", int'(z), 1);
    check("R1", "idle result", int'(f), 0);
    check("R9", "idle carry", int'(c), 0);
    for (int s = 0; s < 8; s++)
      for (int ua = 0; ua < SPAN; ua++)
        for (int ub = 0; ub < SPAN; ub++)
          run_vector(ua, ub, s);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule